// File: doc/BRIEF.md
# Console Keyboard and Display Port

This block is a console peripheral on a 16-bit word bus. A processor polls it or takes interrupts from it. The keyboard side captures one 8-bit character code at a time from a typed-key strobe. It holds that character until software reads it, and it drops any keys typed in the meantime. The display side accepts one character written by software and emits it on a one-cycle strobe. It then stays busy until the display device signals completion. A software-set enable bit lets a waiting keyboard character raise an interrupt request.

Each side is a small two-state machine. The keyboard machine has the states KB_EMPTY and KB_FULL. It moves KB_EMPTY→KB_FULL on a typed key and KB_FULL→KB_EMPTY on a read of the keyboard data register. The display machine has the states DP_READY and DP_BUSY. It moves DP_READY→DP_BUSY on an accepted write of the display data register and DP_BUSY→DP_READY on the display-done input. Bus reads are combinational. A read returns data in the same cycle that the read strobe is high, and any side effect of the read takes place at the clock edge that ends that cycle.

Top module: `con_port`

## Requirements
- R1: After reset the keyboard is in KB_EMPTY with interrupt enable 0, the display is in DP_READY, kbd_irq is 0 and disp_strobe is 0.
- R2: A key strobe in KB_EMPTY stores key_code. From the next cycle, keyboard status (xFE00) reads bit 15 = 1, and keyboard data (xFE02) reads {8'h00, code}.
- R3: A key strobe in KB_FULL is dropped, and the stored code is unchanged.
- R4: A read of keyboard data in KB_FULL returns the machine to KB_EMPTY, so status bit 15 reads 0 from the next cycle. A read of keyboard status changes nothing.
- R5: A write to keyboard status loads the interrupt enable from wdata bit 14. Writes to bit 15 of either status register have no effect.
- R6: kbd_irq is 1 exactly while keyboard status bit 15 and bit 14 are both 1.
- R7: A write to display data (xFE06) in DP_READY gives disp_strobe high for exactly the next cycle, with disp_code = wdata[7:0]. From that cycle, display status (xFE04) reads bit 15 = 0.
- R8: A write to display data in DP_BUSY is ignored: no strobe is produced and disp_code is unchanged.
- R9: disp_done sampled high in DP_BUSY makes display status bit 15 read 1 from the next cycle.
- R10: These read as 0: display data, every unused bit, every address other than the four registers, and bus_rdata whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high |
| key_strobe | input | 1 | A key was typed |
| key_code | input | 8 | Code of the typed key |
| disp_done | input | 1 | Display finished the last character |
| disp_strobe | output | 1 | One-cycle pulse carrying a character to the display |
| disp_code | output | 8 | Character for the display |
| kbd_irq | output | 1 | Keyboard interrupt request |

## Verification
The in-module assertions check the per-cycle rules on every cycle. They cover capture into KB_FULL, holding the code while keys are dropped, clearing on a data read, the strobe and busy transition after an accepted display write, the absence of a strobe for writes while busy, the return to DP_READY after disp_done, and agreement of the interrupt line with a status read. Some behaviour shows only in the bench's scenarios. These include the exact register addresses and the bit layout seen through reads, the no-effect writes to ready bits, the zero reads of unmapped and write-only locations, and the ordering of the characters delivered to the display against those written, which the scoreboard compares one by one.

// File: rtl/con_pkg.sv
package con_pkg;
    typedef enum logic {
        KB_EMPTY,
        KB_FULL
    } kb_state_t;

    typedef enum logic {
        DP_READY,
        DP_BUSY
    } dp_state_t;

    localparam int NUM_REGS = 4;
    localparam int REG_KSTAT = 0;
    localparam int REG_KDATA = 1;
    localparam int REG_DSTAT = 2;
    localparam int REG_DDATA = 3;
endpackage

// File: rtl/con_addr_dec.sv
module con_addr_dec #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE00,
    parameter int NREG = 4,
    parameter int STRIDE = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel
);
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign sel[i] = (addr == BASE_ADDR + ADDR_W'(i * STRIDE));
    end
endmodule

// File: rtl/con_kbd_ch.sv
module con_kbd_ch
    import con_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_strobe,
    input  logic [CHAR_W-1:0] key_code,
    input  logic              rd_data,
    input  logic              wr_ctl,
    input  logic              ie_in,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] code,
    output logic              irq
);
    kb_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            KB_EMPTY: if (key_strobe) state_nx = KB_FULL;
            KB_FULL:  if (rd_data)    state_nx = KB_EMPTY;
            default:  state_nx = KB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= KB_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
            ie   <= 1'b0;
        end else begin
            if (state == KB_EMPTY && key_strobe) code <= key_code;
            if (wr_ctl) ie <= ie_in;
        end
    end

    assign ready = (state == KB_FULL);
    assign irq   = ready & ie;

    // R2
    kb_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && key_strobe) |=> (ready && code == $past(key_code)));
    // R3
    kb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && key_strobe && !rd_data) |=> (ready && $stable(code)));
    // R4
    kb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rd_data) |=> !ready);
endmodule

// File: rtl/con_disp_ch.sv
module con_disp_ch
    import con_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic [CHAR_W-1:0] wdata,
    input  logic              disp_done,
    output logic              ready,
    output logic              disp_strobe,
    output logic [CHAR_W-1:0] disp_code
);
    dp_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            DP_READY: if (wr_data)   state_nx = DP_BUSY;
            DP_BUSY:  if (disp_done) state_nx = DP_READY;
            default:  state_nx = DP_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DP_READY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_strobe <= 1'b0;
            disp_code   <= '0;
        end else begin
            disp_strobe <= (state == DP_READY) && wr_data;
            if (state == DP_READY && wr_data) disp_code <= wdata;
        end
    end

    assign ready = (state == DP_READY);

    // R7
    dp_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_data) |=> (disp_strobe && !ready && disp_code == $past(wdata)));
    // R8
    dp_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && wr_data) |=> (!disp_strobe && $stable(disp_code)));
    // R9
    dp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && disp_done) |=> ready);
endmodule

// File: rtl/con_port.sv
module con_port
    import con_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              key_strobe,
    input  logic [CHAR_W-1:0] key_code,
    input  logic              disp_done,
    output logic              disp_strobe,
    output logic [CHAR_W-1:0] disp_code,
    output logic              kbd_irq
);
    localparam int RDY_BIT = DATA_W - 1;
    localparam int IE_BIT  = DATA_W - 2;

    logic [NUM_REGS-1:0] sel;
    logic                kb_ready, kb_ie, dp_ready;
    logic [CHAR_W-1:0]   kb_code;
    logic                unused_wdata_bits;

    assign unused_wdata_bits = ^{bus_wdata[DATA_W-1], bus_wdata[IE_BIT-1:CHAR_W]};

    con_addr_dec #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NREG(NUM_REGS), .STRIDE(2)
    ) i_dec (
        .addr(bus_addr), .sel(sel)
    );

    con_kbd_ch #(.CHAR_W(CHAR_W)) i_kbd (
        .clk(clk), .rst_n(rst_n),
        .key_strobe(key_strobe), .key_code(key_code),
        .rd_data(bus_rd && sel[REG_KDATA]),
        .wr_ctl(bus_wr && sel[REG_KSTAT]),
        .ie_in(bus_wdata[IE_BIT]),
        .ready(kb_ready), .ie(kb_ie), .code(kb_code), .irq(kbd_irq)
    );

    con_disp_ch #(.CHAR_W(CHAR_W)) i_disp (
        .clk(clk), .rst_n(rst_n),
        .wr_data(bus_wr && sel[REG_DDATA]),
        .wdata(bus_wdata[CHAR_W-1:0]),
        .disp_done(disp_done),
        .ready(dp_ready), .disp_strobe(disp_strobe), .disp_code(disp_code)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel[REG_KSTAT]) begin
                bus_rdata[RDY_BIT] = kb_ready;
                bus_rdata[IE_BIT]  = kb_ie;
            end else if (sel[REG_KDATA]) begin
                bus_rdata[CHAR_W-1:0] = kb_code;
            end else if (sel[REG_DSTAT]) begin
                bus_rdata[RDY_BIT] = dp_ready;
            end
        end
    end

    // R6
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel[REG_KSTAT]) |-> (kbd_irq == (bus_rdata[RDY_BIT] && bus_rdata[IE_BIT])));
    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || sel == '0 || sel[REG_DDATA]) |-> (bus_rdata == '0));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!kb_ready && !kb_ie && dp_ready && !disp_strobe));
endmodule

// File: tb/test_con_port.sv
module test_con_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        key_strobe = 1'b0;
    logic [7:0]  key_code = '0;
    logic        disp_done = 1'b0;
    logic        disp_strobe;
    logic [7:0]  disp_code;
    logic        kbd_irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    localparam logic [15:0] A_KS = 16'hFE00, A_KD = 16'hFE02,
                            A_DS = 16'hFE04, A_DD = 16'hFE06;

    always #10 clk = ~clk;

    con_port i_con_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .key_strobe(key_strobe), .key_code(key_code), .disp_done(disp_done),
        .disp_strobe(disp_strobe), .disp_code(disp_code), .kbd_irq(kbd_irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd_check(input string tag, input logic [15:0] addr, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = addr; bus_rd = 1'b1;
        #1 check(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [15:0] addr, input logic [15:0] data);
        @(negedge clk);
        bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: a display write expected to be accepted pushes its character
    task automatic disp_put(input logic [7:0] ch, input bit accept);
        if (accept) exp_q.push_back(ch);
        wr(A_DD, {8'hA5, ch});
    endtask

    task automatic type_key(input logic [7:0] ch);
        @(negedge clk);
        key_code = ch; key_strobe = 1'b1;
        @(negedge clk);
        key_strobe = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        disp_done = 1'b1;
        @(negedge clk);
        disp_done = 1'b0;
    endtask

    // monitor: each display strobe must match the oldest expected character
    always @(negedge clk) begin : mon
        logic [7:0] e;
        if (rst_n && disp_strobe) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R8 unexpected strobe act=%h exp=none", disp_code);
            end else begin
                e = exp_q.pop_front();
                check("R7 strobe code", {8'h00, disp_code}, {8'h00, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1 check("R1 irq", {15'b0, kbd_irq}, 16'h0);
        check("R1 strobe", {15'b0, disp_strobe}, 16'h0);
        rd_check("R1 kstat", A_KS, 16'h0000);
        rd_check("R1 dstat", A_DS, 16'h8000);

        // R2 capture, R4 clear by data read
        type_key(8'h41);
        rd_check("R2 kstat ready", A_KS, 16'h8000);
        rd_check("R2 kdata", A_KD, 16'h0041);
        rd_check("R4 kstat cleared", A_KS, 16'h0000);

        // R4 status read does not clear; R3 drop while full
        type_key(8'h42);
        rd_check("R4 kstat read1", A_KS, 16'h8000);
        rd_check("R4 kstat read2", A_KS, 16'h8000);
        type_key(8'h43);
        rd_check("R3 kdata kept", A_KD, 16'h0042);
        type_key(8'hF7);
        rd_check("R2 kdata high code", A_KD, 16'h00F7);

        // R5 enable, R6 irq
        wr(A_KS, 16'h4000);
        rd_check("R5 ie set", A_KS, 16'h4000);
        #1 check("R6 irq idle", {15'b0, kbd_irq}, 16'h0);
        type_key(8'h55);
        #1 check("R6 irq raised", {15'b0, kbd_irq}, 16'h1);
        wr(A_KS, 16'h0000);
        rd_check("R5 ready not writable", A_KS, 16'h8000);
        #1 check("R6 irq gated", {15'b0, kbd_irq}, 16'h0);
        wr(A_KS, 16'h4000);
        #1 check("R6 irq re-enabled", {15'b0, kbd_irq}, 16'h1);
        rd_check("R4 kdata", A_KD, 16'h0055);
        #1 check("R6 irq after read", {15'b0, kbd_irq}, 16'h0);
        wr(A_KS, 16'hC000);
        rd_check("R5 ready not settable", A_KS, 16'h4000);

        // R7 accept, R8 ignore while busy, R9 done
        disp_put(8'h34, 1'b1);
        rd_check("R7 dstat busy", A_DS, 16'h0000);
        disp_put(8'h78, 1'b0);
        wr(A_DS, 16'h8000);
        rd_check("R5 dstat not writable", A_DS, 16'h0000);
        @(negedge clk);
        disp_done = 1'b1; bus_addr = A_DS; bus_rd = 1'b1;
        #1 check("R9 still busy", bus_rdata, 16'h0000);
        @(negedge clk);
        disp_done = 1'b0;
        #1 check("R9 ready after done", bus_rdata, 16'h8000);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R8 code unchanged", {8'h00, disp_code}, 16'h0034);
        disp_put(8'h61, 1'b1);
        pulse_done();
        pulse_done();
        rd_check("R9 stray done", A_DS, 16'h8000);
        disp_put(8'h0A, 1'b1);
        pulse_done();

        // R10 zero reads
        rd_check("R10 ddata", A_DD, 16'h0000);
        rd_check("R10 odd addr", 16'hFE01, 16'h0000);
        rd_check("R10 past end", 16'hFE08, 16'h0000);
        rd_check("R10 low addr", 16'h0000, 16'h0000);
        bus_addr = A_DS;
        #1 check("R10 no read", bus_rdata, 16'h0000);

        repeat (3) @(negedge clk);
        check("R7 all delivered", 16'(exp_q.size()), 16'h0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule